// File: doc/BRIEF.md
# Walsh Code Multi-Sender Spreader

The block lets several senders share one channel in the same chip periods. Each sender offers one data bit per symbol, a valid flag and the index of the orthogonal code it uses. The block turns the bit into a sign, multiplies that sign by each chip of the selected code, and adds the chips of all active senders. The result is one signed, multi-level value per clock.

The codes are the rows of a Sylvester Hadamard matrix of order L. Each chip is computed from the row and column indices, so the block stores no code table. A receiver that correlates the channel over one symbol with its own code gets back its sender's bit, scaled by L. The signals of the other senders cancel.

A free-running chip counter defines each symbol as L clock cycles. The block captures the sender inputs once per symbol and holds them for the whole symbol. A marker output flags the first chip of each symbol.

Top module: `walsh_spreader`

## Requirements
- R1: Chip j of code k is +1 when popcount(k AND j) is even and −1 when it is odd. The code index is tx_code[i*IDXW +: IDXW] for sender i, with IDXW = log2(L).
- R2: A data bit of 1 gives sign +1 and a data bit of 0 gives sign −1. The sender's chip is that sign times the code chip.
- R3: On every cycle, chan_sum equals the sum of the chips of all valid senders for the current chip index.
- R4: A sender whose captured valid flag is 0 adds 0 to chan_sum for every chip of that symbol.
- R5: chan_sum is two's complement with $clog2(N+1)+1 bits. It stays within −N..+N and shows exactly ±N when all N senders are valid with the same code and the same bit.
- R6: The inputs are captured only on the clock edge that ends chip L−1. The captured values drive all L chips of the next symbol. Input changes at any other time have no effect.
- R7: sym_start is 1 on chip 0 and 0 on chips 1..L−1, so it pulses once every L cycles.
- R8: While rst_n is low, the chip counter is 0 and all captured inputs are cleared. The first symbol after reset therefore shows chan_sum = 0 on every chip, with sym_start high on its chip 0.
- R9: When the valid senders use distinct codes, correlating chan_sum over one symbol with the code of sender k gives +L or −L (the sign of k's bit) if k is valid, and 0 if k is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit | input | N | Data bit of each sender |
| tx_vld | input | N | Valid flag of each sender |
| tx_code | input | N*IDXW | Packed code index of each sender |
| chan_sum | output | $clog2(N+1)+1 | Signed channel value for the current chip |
| sym_start | output | 1 | High on chip 0 of each symbol |

## Verification
The hardest behaviour to show from the ports is the capture point. A fault that samples a cycle early, samples every cycle, or drops the hold register can still produce correct sums whenever the inputs happen to stay steady. The stimulus therefore changes the inputs to different values in the middle of a symbol and restores them before the capture edge. In a separate case it presents new values only during the final chip. A symbol is checked against values captured at the wrong edge only if it differs from the correct one, so each case checks the chips of the following symbol against the values that should have been captured.

// File: rtl/walsh_spreader.sv
module walsh_spreader #(
  parameter int N = 4,
  parameter int L = 8,
  localparam int IDXW = (L > 1) ? $clog2(L) : 1,
  localparam int SUMW = $clog2(N + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           tx_bit,
  input  logic [N-1:0]           tx_vld,
  input  logic [N*IDXW-1:0]      tx_code,
  output logic signed [SUMW-1:0] chan_sum,
  output logic                   sym_start
);

  logic [IDXW-1:0]   chip;
  logic [N-1:0]      h_bit;
  logic [N-1:0]      h_vld;
  logic [N*IDXW-1:0] h_code;
  logic              last_chip;

  assign last_chip = (chip == IDXW'(L - 1));
  assign sym_start = (chip == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip   <= '0;
      h_bit  <= '0;
      h_vld  <= '0;
      h_code <= '0;
    end else begin
      chip <= last_chip ? '0 : chip + 1'b1;
      if (last_chip) begin
        h_bit  <= tx_bit;
        h_vld  <= tx_vld;
        h_code <= tx_code;
      end
    end
  end

  logic signed [SUMW-1:0] term [N];

  for (genvar i = 0; i < N; i++) begin : g_snd
    logic neg_chip;
    assign neg_chip = ^(h_code[i*IDXW +: IDXW] & chip);
    assign term[i]  = !h_vld[i]              ? SUMW'(0)  :
                      (h_bit[i] ^ neg_chip)  ? SUMW'(1)  : -SUMW'(1);
  end

  always_comb begin
    chan_sum = '0;
    for (int i = 0; i < N; i++) chan_sum = chan_sum + term[i];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sum <= SUMW'(N)) && (chan_sum >= -SUMW'(N))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_vld == '0) |-> (chan_sum == '0)); // R4

  AST_SUM_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sum[0] == ($countones(h_vld) % 2 == 1)); // R3

  AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_start |-> ($stable(h_bit) && $stable(h_vld) && $stable(h_code))); // R6

  AST_MARK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (L == 1) || !sym_start); // R7

endmodule

// File: tb/tb_walsh_spreader.sv
module tb_walsh_spreader;
  localparam int N = 4;
  localparam int L = 8;
  localparam int IDXW = $clog2(L);
  localparam int SUMW = $clog2(N + 1) + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] tx_bit = '0, tx_vld = '0;
  logic [N*IDXW-1:0] tx_code = '0;
  logic signed [SUMW-1:0] chan_sum;
  logic sym_start;

  int n_chk = 0, n_bad = 0;

  walsh_spreader #(.N(N), .L(L)) dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_vld(tx_vld),
    .tx_code(tx_code), .chan_sum(chan_sum), .sym_start(sym_start));

  always #2 clk = ~clk;

  function automatic int code_chip(int k, int j);
    return ($countones(k & j) % 2 == 0) ? 1 : -1;
  endfunction

  function automatic int exp_sum(logic [N-1:0] b, logic [N-1:0] v,
                                 logic [N*IDXW-1:0] c, int j);
    int s = 0;
    for (int i = 0; i < N; i++)
      if (v[i]) s += (b[i] ? 1 : -1) * code_chip(int'(c[i*IDXW +: IDXW]), j);
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic to_chip0();
    @(negedge clk);
    while (!sym_start) @(negedge clk);
  endtask

  // Checks the L chips of the symbol that starts at the current negedge.
  task automatic check_symbol(string req, logic [N-1:0] b, logic [N-1:0] v,
                              logic [N*IDXW-1:0] c, bit corr);
    int acc [N];
    for (int k = 0; k < N; k++) acc[k] = 0;
    for (int j = 0; j < L; j++) begin
      check({req, " chip sum"}, int'(chan_sum), exp_sum(b, v, c, j));
      check("R7 sym_start", int'(sym_start), (j == 0) ? 1 : 0);
      for (int k = 0; k < N; k++)
        acc[k] += int'(chan_sum) * code_chip(int'(c[k*IDXW +: IDXW]), j);
      if (j != L - 1) @(negedge clk);
    end
    if (corr)
      for (int k = 0; k < N; k++)
        check("R9 correlation", acc[k], v[k] ? (b[k] ? L : -L) : 0);
  endtask

  task automatic send(string req, logic [N-1:0] b, logic [N-1:0] v,
                      logic [N*IDXW-1:0] c, bit corr);
    to_chip0();
    tx_bit = b; tx_vld = v; tx_code = c;
    repeat (L) @(negedge clk);
    check_symbol(req, b, v, c, corr);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 sym_start in reset", int'(sym_start), 1);
    check("R8 sum in reset", int'(chan_sum), 0);
    tx_bit = '1; tx_vld = '1; tx_code = {3'd3, 3'd2, 3'd1, 3'd0};
    @(negedge clk);
    rst_n = 1;
    check_symbol("R8 first symbol", '0, '0, '0, 1'b0);
  endtask

  task automatic t_single();
    for (int k = 0; k < L; k++) begin
      send("R1", 4'b0001, 4'b0001, {9'd0, 3'(k)}, 1'b0);
      send("R2", 4'b0000, 4'b0001, {9'd0, 3'(k)}, 1'b0);
    end
  endtask

  task automatic t_all();
    send("R3", 4'b1010, 4'b1111, {3'd7, 3'd5, 3'd2, 3'd0}, 1'b1);
    send("R3", 4'b0110, 4'b1111, {3'd1, 3'd3, 3'd4, 3'd6}, 1'b1);
    send("R3", 4'b1111, 4'b1111, {3'd4, 3'd5, 3'd6, 3'd7}, 1'b1);
  endtask

  task automatic t_partial();
    send("R4", 4'b1111, 4'b0101, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1);
    send("R4", 4'b0011, 4'b0000, {3'd1, 3'd2, 3'd3, 3'd4}, 1'b1);
  endtask

  task automatic t_extreme();
    send("R5 plus", 4'b1111, 4'b1111, {4{3'd5}}, 1'b0);
    send("R5 minus", 4'b0000, 4'b1111, {4{3'd3}}, 1'b0);
  endtask

  task automatic t_hold();
    logic [N-1:0] b = 4'b1001, v = 4'b1111;
    logic [N*IDXW-1:0] c = {3'd6, 3'd1, 3'd3, 3'd2};
    to_chip0();
    tx_bit = b; tx_vld = v; tx_code = c;
    repeat (2) @(negedge clk);
    tx_bit = ~b; tx_vld = 4'b0110; tx_code = {3'd0, 3'd0, 3'd7, 3'd7};
    repeat (3) @(negedge clk);
    tx_bit = b; tx_vld = v; tx_code = c;
    repeat (L - 5) @(negedge clk);
    check_symbol("R6 mid change", b, v, c, 1'b1);
    to_chip0();
    tx_bit = '0; tx_vld = '0; tx_code = '0;
    repeat (L - 1) @(negedge clk);
    tx_bit = 4'b0111; tx_vld = 4'b1011; tx_code = {3'd2, 3'd4, 3'd6, 3'd1};
    @(negedge clk);
    tx_vld = '0;
    check_symbol("R6 last chip", 4'b0111, 4'b1011, {3'd2, 3'd4, 3'd6, 3'd1}, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_all();
    t_partial();
    t_extreme();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule